// File: doc/BRIEF.md
# Registered Bidirectional Byte-Lane Transceiver

This block joins two 16-bit ports, A and B, split into two byte lanes that are controlled separately. Each lane has two paths. One carries data from A to B and the other from B to A. Each path has its own storage register, its own capture strobe and its own select. When a lane drives a port, that port receives either the live input from the opposite port or the value held in the matching register. Driving the same controls on both lanes gives a full 16-bit transceiver.

Each physical port is split into an input bus, an output bus and one drive-enable bit per lane. This keeps the design free of internal tristates. Everything runs on one system clock. The capture strobes are ordinary synchronous inputs, and a strobe loads its register on the first clock cycle in which the strobe is seen high after being low. Storage works whatever the output enable and the direction are, so a lane can capture from both ports while it is isolated. The ports have no valid/ready handshake and no back-pressure. The port outputs are combinational and follow the inputs in the same cycle.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears both storage registers of every lane to zero.
- R2: A cycle in which a lane's stb_ab is 1, when it was 0 in the previous cycle, loads that lane's A-side register with the lane's a_in bits at that clock edge. This happens whatever oe_n and dir are, and the new value is visible from the next cycle.
- R3: In the same way, a rising stb_ba loads the lane's B-side register with the lane's b_in bits, whatever oe_n and dir are.
- R4: A register keeps its value in every cycle that is not a rising strobe cycle for it. A strobe held high loads only once.
- R5: With oe_n=1 the lane is isolated: both drive-enable bits of the lane are 0.
- R6: With oe_n=0, dir=1 sets b_drv and clears a_drv, and dir=0 sets a_drv and clears b_drv. A lane never drives both ports at once.
- R7: When b_drv is 1 and sel_ab=0 (transparent), the lane's b_out equals its a_in in the same cycle.
- R8: When b_drv is 1 and sel_ab=1 (stored), the lane's b_out equals the A-side register. After a rising stb_ab cycle, b_out shows the new value in the following cycle.
- R9: When a_drv is 1, a_out equals b_in if sel_ba=0 and the B-side register if sel_ba=1.
- R10: Lane k covers data bits [8k+7:8k] and bit k of every control and drive-enable signal, and the lanes do not affect each other.
- R11: An output bus lane whose drive-enable is 0 carries all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | 2 | Per-lane active-low output enable |
| dir | input | 2 | Per-lane direction: 1 drives B, 0 drives A |
| stb_ab | input | 2 | Per-lane capture strobe for the A-side register |
| stb_ba | input | 2 | Per-lane capture strobe for the B-side register |
| sel_ab | input | 2 | Per-lane B source: 0 live A, 1 stored A |
| sel_ba | input | 2 | Per-lane A source: 0 live B, 1 stored B |
| a_in | input | 16 | Port A input data |
| a_out | output | 16 | Port A output data |
| a_drv | output | 2 | Per-lane drive-enable for port A |
| b_in | input | 16 | Port B input data |
| b_out | output | 16 | Port B output data |
| b_drv | output | 2 | Per-lane drive-enable for port B |

## Verification
Capture and output can fall in the same cycle: a register can be loaded on its strobe edge while its lane drives the other port from that same register in stored mode. The opposite port can also be captured while the lane drives it. Directed steps raise stb_ab while B is driven in stored mode. The bench expects the old register value in that cycle and the new value in the next. Both registers are also loaded while the lane is isolated and read back afterwards through stored mode. Random control sequences then overlap strobes, selects and direction changes, and a bench model judges every lane in every cycle, including the rule that both ports are never driven together.

// File: rtl/xr_pkg.sv
package xr_pkg;
  typedef enum logic {
    XR_TOWARD_A = 1'b0,
    XR_TOWARD_B = 1'b1
  } xr_dir_e;

  typedef enum logic {
    XR_SRC_LIVE   = 1'b0,
    XR_SRC_STORED = 1'b1
  } xr_src_e;
endpackage

// File: rtl/xr_edge.sv
module xr_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_q;

  // tracks the strobe even during reset so no false edge appears on release
  always_ff @(posedge clk) begin
    lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/xr_store.sv
module xr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/xr_lane.sv
module xr_lane
  import xr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         stb_ab,
  input  logic         stb_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         a_drv,
  output logic         b_drv
);
  logic [1:0]   rise;
  logic [W-1:0] reg_a;
  logic [W-1:0] reg_b;
  logic [W-1:0] src_b;
  logic [W-1:0] src_a;

  xr_edge #(.N(2)) u_edge (
    .clk  (clk),
    .lvl  ({stb_ba, stb_ab}),
    .rise (rise)
  );

  xr_store #(.W(W)) u_store_a (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rise[0]),
    .d     (a_in),
    .q     (reg_a)
  );

  xr_store #(.W(W)) u_store_b (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rise[1]),
    .d     (b_in),
    .q     (reg_b)
  );

  always_comb begin
    src_b = (xr_src_e'(sel_ab) == XR_SRC_STORED) ? reg_a : a_in;
    src_a = (xr_src_e'(sel_ba) == XR_SRC_STORED) ? reg_b : b_in;
    b_drv = !oe_n && (xr_dir_e'(dir) == XR_TOWARD_B);
    a_drv = !oe_n && (xr_dir_e'(dir) == XR_TOWARD_A);
    b_out = b_drv ? src_b : '0;
    a_out = a_drv ? src_a : '0;
  end

  assert_one_side_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_drv && b_drv));

  assert_isolate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!a_drv && !b_drv && a_out == '0 && b_out == '0));

  assert_load_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_ab && !$past(stb_ab)) |=> (reg_a == $past(a_in)));

  assert_load_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_ba && !$past(stb_ba)) |=> (reg_b == $past(b_in)));

  assert_hold_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb_ab && !$past(stb_ab)) |=> $stable(reg_a));

  assert_hold_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb_ba && !$past(stb_ba)) |=> $stable(reg_b));

  assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (b_drv && !sel_ab) |-> (b_out == a_in));
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] oe_n,
  input  logic [LANES-1:0] dir,
  input  logic [LANES-1:0] stb_ab,
  input  logic [LANES-1:0] stb_ba,
  input  logic [LANES-1:0] sel_ab,
  input  logic [LANES-1:0] sel_ba,
  input  logic [DW-1:0]    a_in,
  output logic [DW-1:0]    a_out,
  output logic [LANES-1:0] a_drv,
  input  logic [DW-1:0]    b_in,
  output logic [DW-1:0]    b_out,
  output logic [LANES-1:0] b_drv
);
  // R10: lane k owns bits [k*LANE_W +: LANE_W] and control bit k
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    xr_lane #(.W(LANE_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .oe_n   (oe_n[k]),
      .dir    (dir[k]),
      .stb_ab (stb_ab[k]),
      .stb_ba (stb_ba[k]),
      .sel_ab (sel_ab[k]),
      .sel_ba (sel_ba[k]),
      .a_in   (a_in[k*LANE_W +: LANE_W]),
      .b_in   (b_in[k*LANE_W +: LANE_W]),
      .a_out  (a_out[k*LANE_W +: LANE_W]),
      .b_out  (b_out[k*LANE_W +: LANE_W]),
      .a_drv  (a_drv[k]),
      .b_drv  (b_drv[k])
    );
  end

  assert_undriven_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (a_drv == '0) |-> (a_out == '0));
endmodule

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
  localparam int CLK_P = 10;
  localparam int L = 2;
  localparam int W = 8;
  localparam int DW = L * W;

  logic clk = 1'b0;
  logic rst_n;
  logic [L-1:0] oe_n, dir, stb_ab, stb_ba, sel_ab, sel_ba;
  logic [DW-1:0] a_in, b_in, a_out, b_out;
  logic [L-1:0] a_drv, b_drv;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [W-1:0] m_a [L];
  logic [W-1:0] m_b [L];
  logic [L-1:0] m_pab, m_pba;

  always #(CLK_P/2) clk = ~clk;

  bus_xcvr_reg #(.LANES(L), .LANE_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
    .stb_ab(stb_ab), .stb_ba(stb_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] exp_b(int k);
    if (oe_n[k] || !dir[k]) return '0;
    return sel_ab[k] ? m_a[k] : a_in[k*W +: W];
  endfunction

  function automatic logic [W-1:0] exp_a(int k);
    if (oe_n[k] || dir[k]) return '0;
    return sel_ba[k] ? m_b[k] : b_in[k*W +: W];
  endfunction

  task automatic general_check();
    for (int k = 0; k < L; k++) begin
      chk(!(a_drv[k] && b_drv[k]), "R6 both driven", {a_drv[k], b_drv[k]}, 0);
      chk(a_drv[k] == (!oe_n[k] && !dir[k]), oe_n[k] ? "R5 a_drv" : "R6 a_drv", a_drv[k], !oe_n[k] && !dir[k]);
      chk(b_drv[k] == (!oe_n[k] && dir[k]), oe_n[k] ? "R5 b_drv" : "R6 b_drv", b_drv[k], !oe_n[k] && dir[k]);
      chk(b_out[k*W +: W] == exp_b(k), sel_ab[k] ? "R8 b_out" : "R7 b_out", b_out[k*W +: W], exp_b(k));
      chk(a_out[k*W +: W] == exp_a(k), "R9/R11 a_out", a_out[k*W +: W], exp_a(k));
    end
  endtask

  task automatic settle();
    #(CLK_P/4);
    if (rst_n) general_check();
  endtask

  task automatic advance();
    @(posedge clk);
    for (int k = 0; k < L; k++) begin
      if (!rst_n) begin
        m_a[k] = '0;
        m_b[k] = '0;
      end else begin
        if (stb_ab[k] && !m_pab[k]) m_a[k] = a_in[k*W +: W];
        if (stb_ba[k] && !m_pba[k]) m_b[k] = b_in[k*W +: W];
      end
    end
    m_pab = stb_ab;
    m_pba = stb_ba;
    @(negedge clk);
  endtask

  task automatic step();
    settle();
    advance();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; oe_n = '1; dir = '0; stb_ab = '0; stb_ba = '0;
    sel_ab = '0; sel_ba = '0; a_in = '0; b_in = '0;
    m_pab = '0; m_pba = '0;
    for (int k = 0; k < L; k++) begin m_a[k] = 'x; m_b[k] = 'x; end
    @(negedge clk);
    repeat (3) advance();
    rst_n = 1;

    // R1: stored mode after reset shows zero on both paths
    oe_n = 2'b00; dir = 2'b01; sel_ab = 2'b11; sel_ba = 2'b11;
    a_in = 16'hFFFF; b_in = 16'hFFFF;
    settle();
    chk(b_out[7:0] == 8'h00, "R1 lane0 A reg after reset", b_out[7:0], 0);
    chk(a_out[15:8] == 8'h00, "R1 lane1 B reg after reset", a_out[15:8], 0);
    // R10: lane0 drives B, lane1 drives A at the same time
    chk(b_drv == 2'b01 && a_drv == 2'b10, "R10 independent lanes", {a_drv, b_drv}, 4'b1001);
    advance();

    // R2, R3, R5: capture both ports while isolated
    oe_n = 2'b11; a_in = 16'h5A3C; b_in = 16'h96E1; stb_ab = 2'b11; stb_ba = 2'b11;
    settle();
    chk(a_drv == 0 && b_drv == 0 && a_out == 0 && b_out == 0, "R5 isolated", {a_drv, b_drv}, 0);
    advance();
    stb_ab = 0; stb_ba = 0; a_in = 16'h1111; b_in = 16'h2222;
    oe_n = 0; dir = 2'b11; sel_ab = 2'b11;
    settle();
    chk(b_out == 16'h5A3C, "R2 isolated capture of A", b_out, 16'h5A3C);
    advance();
    dir = 2'b00; sel_ba = 2'b11;
    settle();
    chk(a_out == 16'h96E1, "R3 isolated capture of B", a_out, 16'h96E1);
    chk(b_out == 16'h0000, "R11 undriven B is zero", b_out, 0);
    advance();

    // R4: strobe held high loads only once
    dir = 2'b11; sel_ab = 2'b11;
    stb_ab = 2'b11; a_in = 16'h7733; step();
    a_in = 16'hCCEE; step();
    a_in = 16'h0101; step();
    stb_ab = 0; settle();
    chk(b_out == 16'h7733, "R4 held strobe", b_out, 16'h7733);
    advance();

    // R8: capture and stored output in the same cycle
    a_in = 16'hABCD; stb_ab = 2'b11;
    settle();
    chk(b_out == 16'h7733, "R8 old value in capture cycle", b_out, 16'h7733);
    advance();
    stb_ab = 0; a_in = 16'h0000;
    settle();
    chk(b_out == 16'hABCD, "R8 new value next cycle", b_out, 16'hABCD);
    advance();

    // R7/R9 transparent paths, and capture on the driven side while B drives A
    sel_ab = 0; a_in = 16'h3C5A;
    settle();
    chk(b_out == 16'h3C5A, "R7 transparent A to B", b_out, 16'h3C5A);
    advance();
    dir = 2'b00; sel_ba = 2'b00; b_in = 16'hE196; stb_ab = 2'b11; a_in = 16'h4455;
    settle();
    chk(a_out == 16'hE196, "R9 transparent B to A", a_out, 16'hE196);
    advance();
    stb_ab = 0; dir = 2'b11; sel_ab = 2'b11;
    settle();
    chk(b_out == 16'h4455, "R2 capture of driven port", b_out, 16'h4455);
    advance();

    // random control sequences checked every cycle
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 97) == 0) rst_n = 0; else rst_n = 1;
      oe_n   = L'($urandom);
      dir    = L'($urandom);
      sel_ab = L'($urandom);
      sel_ba = L'($urandom);
      stb_ab = L'($urandom);
      stb_ba = L'($urandom);
      a_in   = DW'($urandom);
      b_in   = DW'($urandom);
      step();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule